// File: doc/BRIEF.md
# Serial Core Run/Pause State Controller

This block holds the operating state of a serial-bus mini-core and the sticky flags that software services. Software asks for one of three states: reset, run or pause. An accepted request clears a valid indication. The change then passes through a fixed number of interface-clock cycles, followed by a fixed number of engine-clock ticks. Only after both does the new state take effect, and the valid indication returns high. Software polls that indication before it issues the next request. Pause lets the software refill the transmit queue while bus activity is held. The `run_en` and `pause_en` outputs tell the serial engine which mode is in force.

The block also keeps three groups of sticky flags: service and done flags, core error flags, and bus error flags. The first two groups are cleared by writing ones. Bus error flags clear when software issues a reset-state request. A software-reset strobe returns the core to reset and empties every flag group at once. The serial engine and its queues sit outside the block. They arrive here as level inputs, set pulses and an engine clock-enable tick. An interrupt line is raised while any flag selected in an enable register is set.

Top module: `rps_ctrl`

## Requirements
- R1: After reset, `status_word` reads 0x04 (state 0 = reset, valid set, master-ready clear). The flag words and `bus_err_word` read zero, and `irq`, `run_en` and `pause_en` are low.
- R2: A write with `reg_sel`=0 while valid is set is accepted when `reg_wdata[1:0]` is 0 (reset), 1 (run) or 3 (pause). In the next cycle `status_word[2]` (valid) is low, and `status_word[1:0]` keeps the old state until the change completes.
- R3: A change completes after IF_CYC interface clocks, followed by ENG_CYC cycles in which `eng_tick` is high. Cycles with `eng_tick` low add nothing. With `eng_tick` held high, valid is low for exactly IF_CYC+ENG_CYC samples.
- R4: A state write that arrives while valid is low has no effect. So does a write of encoding 2.
- R5: `status_word` bits 1:0 give the state, bit 2 gives valid and bit 4 gives `mst_ready_in` registered by one cycle. All other bits are zero.
- R6: `run_en` is high only when the state is run and valid is set. `pause_en` is high only when the state is pause and valid is set.
- R7: In `oper_word`, bits 4, 5 and 6 follow `out_not_empty`, `in_not_empty` and `out_full` live. Bits 8 (out service), 9 (in service), 10 (out done) and 11 (in done) are sticky, set by their pulses. Each clears when a write with `reg_sel`=2 carries a 1 at that bit position. A 0 bit leaves its flag unchanged.
- R8: Each `err_set[k]` sets sticky bit k+2 of `err_word` (bits 6:2). Writing 1 at that bit with `reg_sel`=3 clears it. Write bits outside 6:2 have no effect.
- R9: Each `bus_err_set[k]` sets sticky bit k of `bus_err_word`. Only an accepted reset-state request clears these bits; a run request leaves them set.
- R10: A write with `reg_sel`=1 and `reg_wdata[0]`=1 is a software reset. In the next cycle the state is reset with valid set, any change in flight is dropped, and all sticky flags are zero. The enable register keeps its value.
- R11: When a set pulse and a write-one clear hit the same flag in one cycle, the flag ends up set. When a set pulse meets a software reset, the flag ends up clear.
- R12: A write with `reg_sel`=4 loads the interrupt enables: bit 0 for any bus error, bits 6:2 for the matching error flags, bit 8 for out service and bit 9 for in service. `irq` is high in exactly the cycles in which an enabled flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Write target: 0 state, 1 soft reset, 2 operational clear, 3 error clear, 4 interrupt enable |
| reg_wdata | input | 16 | Write data |
| eng_tick | input | 1 | One engine-clock cycle has elapsed |
| mst_ready_in | input | 1 | Serial engine reports its master logic ready |
| out_not_empty | input | 1 | Transmit queue holds data |
| in_not_empty | input | 1 | Receive queue holds data |
| out_full | input | 1 | Transmit queue full |
| out_svc_set | input | 1 | Transmit queue needs service |
| in_svc_set | input | 1 | Receive queue needs service |
| out_done_set | input | 1 | Transmit count reached |
| in_done_set | input | 1 | Receive count reached |
| err_set | input | 5 | Core error events, bit k sets error flag k+2 |
| bus_err_set | input | BUS_ERR_W | Bus protocol error events |
| status_word | output | 8 | State, valid and master-ready |
| oper_word | output | 16 | Queue levels and service/done flags |
| err_word | output | 8 | Core error flags at bits 6:2 |
| bus_err_word | output | BUS_ERR_W | Bus error flags |
| run_en | output | 1 | Engine may run |
| pause_en | output | 1 | Engine frozen for refill |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can collide on the same clock edge. The first is a flag's set pulse against a software write-one clear of that same flag. The second is a set pulse against a software reset. The bench provokes each by raising the pulse at the same negative edge that presents the register write. It then reads the flag at the next sample: set wins over a clear, and a software reset wins over a set. A third collision is a state request that arrives while a change is still in flight. It is judged by checking that the final state is the first request and not the second.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd3
    } core_state_e;

    typedef enum logic [2:0] {
        SEL_STATE = 3'd0,
        SEL_SWRST = 3'd1,
        SEL_OPER  = 3'd2,
        SEL_ERR   = 3'd3,
        SEL_IEN   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_IFACE,
        PH_ENGINE
    } xfer_phase_e;

    // bit positions that software decodes
    localparam int STAT_VALID_BIT = 2;
    localparam int STAT_READY_BIT = 4;
    localparam int OPER_OUT_NE    = 4;
    localparam int OPER_IN_NE     = 5;
    localparam int OPER_OUT_FULL  = 6;
    localparam int OPER_FLAG_LO   = 8;
    localparam int OPER_FLAG_W    = 4;
    localparam int ERR_LO         = 2;
    localparam int ERR_W          = 5;
    localparam int IEN_BUS_BIT    = 0;
    localparam int IEN_SVC_LO     = 8;
    localparam int IEN_SVC_W      = 2;

    localparam logic [15:0] IEN_MASK = 16'h037D;

    function automatic logic state_is_legal(input logic [1:0] s);
        return (s == ST_RESET) || (s == ST_RUN) || (s == ST_PAUSE);
    endfunction

    function automatic logic [7:0] pack_status(input logic [1:0] s,
                                               input logic v,
                                               input logic rdy);
        logic [7:0] w;
        w = 8'h00;
        w[1:0] = s;
        w[STAT_VALID_BIT] = v;
        w[STAT_READY_BIT] = rdy;
        return w;
    endfunction

endpackage

// File: rtl/rps_state_seq.sv
module rps_state_seq
    import rps_pkg::*;
#(
    parameter int IF_CYC  = 3,
    parameter int ENG_CYC = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       swrst,
    input  logic       req_wr,
    input  logic [1:0] req_state,
    input  logic       eng_tick,
    output logic [1:0] cur_state,
    output logic       valid,
    output logic       accepted
);

    localparam int CNT_MAX = (IF_CYC > ENG_CYC) ? IF_CYC : ENG_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] IF_LAST  = CNT_W'(IF_CYC - 1);
    localparam logic [CNT_W-1:0] ENG_LAST = CNT_W'(ENG_CYC - 1);

    xfer_phase_e      phase;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       pend;

    assign accepted = req_wr && valid && !swrst && state_is_legal(req_state);

    always_ff @(posedge clk) begin
        if (rst || swrst) begin
            cur_state <= ST_RESET;
            valid     <= 1'b1;
            phase     <= PH_IDLE;
            cnt       <= '0;
            pend      <= ST_RESET;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accepted) begin
                        pend  <= req_state;
                        valid <= 1'b0;
                        phase <= PH_IFACE;
                        cnt   <= '0;
                    end
                end
                PH_IFACE: begin
                    if (cnt == IF_LAST) begin
                        phase <= PH_ENGINE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_ENGINE: begin
                    if (eng_tick) begin
                        if (cnt == ENG_LAST) begin
                            cur_state <= pend;
                            valid     <= 1'b1;
                            phase     <= PH_IDLE;
                            cnt       <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2
    accept_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
        accepted |=> !valid);

    // R2
    state_held_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid && !swrst) |=> (valid || $stable(cur_state)));

    // R3
    finish_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(valid) && !$past(swrst)) |-> $past(eng_tick));

endmodule

// File: rtl/rps_flag_bank.sv
module rps_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic [W-1:0] set,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr_en && clr_mask[i]) begin
                q[i] <= 1'b0;
            end
        end
    end

    // R11
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush && (|set)) |=> ((q & $past(set)) == $past(set)));

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (q == '0));

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush && !clr_en) |=> ((q & $past(q)) == $past(q)));

endmodule

// File: rtl/rps_ctrl.sv
module rps_ctrl
    import rps_pkg::*;
#(
    parameter int IF_CYC    = 3,
    parameter int ENG_CYC   = 3,
    parameter int BUS_ERR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_sel,
    input  logic [15:0]          reg_wdata,
    input  logic                 eng_tick,
    input  logic                 mst_ready_in,
    input  logic                 out_not_empty,
    input  logic                 in_not_empty,
    input  logic                 out_full,
    input  logic                 out_svc_set,
    input  logic                 in_svc_set,
    input  logic                 out_done_set,
    input  logic                 in_done_set,
    input  logic [4:0]           err_set,
    input  logic [BUS_ERR_W-1:0] bus_err_set,
    output logic [7:0]           status_word,
    output logic [15:0]          oper_word,
    output logic [7:0]           err_word,
    output logic [BUS_ERR_W-1:0] bus_err_word,
    output logic                 run_en,
    output logic                 pause_en,
    output logic                 irq
);

    logic                    swrst;
    logic                    state_wr;
    logic                    accepted;
    logic                    bus_clr;
    logic [1:0]              cur_state;
    logic                    valid;
    logic                    rdy_q;
    logic [15:0]             ien_q;
    logic [OPER_FLAG_W-1:0]  oper_set;
    logic [OPER_FLAG_W-1:0]  oper_q;
    logic [ERR_W-1:0]        err_q;
    logic [BUS_ERR_W-1:0]    bus_q;

    assign swrst    = reg_wr && (reg_sel == SEL_SWRST) && reg_wdata[0];
    assign state_wr = reg_wr && (reg_sel == SEL_STATE);
    assign bus_clr  = accepted && (reg_wdata[1:0] == ST_RESET);
    assign oper_set = {in_done_set, out_done_set, in_svc_set, out_svc_set};

    rps_state_seq #(
        .IF_CYC  (IF_CYC),
        .ENG_CYC (ENG_CYC)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .swrst     (swrst),
        .req_wr    (state_wr),
        .req_state (reg_wdata[1:0]),
        .eng_tick  (eng_tick),
        .cur_state (cur_state),
        .valid     (valid),
        .accepted  (accepted)
    );

    rps_flag_bank #(.W(OPER_FLAG_W)) i_oper_flags (
        .clk      (clk),
        .rst      (rst),
        .flush    (swrst),
        .set      (oper_set),
        .clr_en   (reg_wr && (reg_sel == SEL_OPER)),
        .clr_mask (reg_wdata[OPER_FLAG_LO +: OPER_FLAG_W]),
        .q        (oper_q)
    );

    rps_flag_bank #(.W(ERR_W)) i_err_flags (
        .clk      (clk),
        .rst      (rst),
        .flush    (swrst),
        .set      (err_set),
        .clr_en   (reg_wr && (reg_sel == SEL_ERR)),
        .clr_mask (reg_wdata[ERR_LO +: ERR_W]),
        .q        (err_q)
    );

    rps_flag_bank #(.W(BUS_ERR_W)) i_bus_flags (
        .clk      (clk),
        .rst      (rst),
        .flush    (swrst),
        .set      (bus_err_set),
        .clr_en   (bus_clr),
        .clr_mask ({BUS_ERR_W{1'b1}}),
        .q        (bus_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= 1'b0;
            ien_q <= '0;
        end else begin
            rdy_q <= mst_ready_in;
            if (reg_wr && (reg_sel == SEL_IEN)) begin
                ien_q <= reg_wdata & IEN_MASK;
            end
        end
    end

    always_comb begin
        status_word = pack_status(cur_state, valid, rdy_q);
        oper_word = '0;
        oper_word[OPER_OUT_NE]   = out_not_empty;
        oper_word[OPER_IN_NE]    = in_not_empty;
        oper_word[OPER_OUT_FULL] = out_full;
        oper_word[OPER_FLAG_LO +: OPER_FLAG_W] = oper_q;
        err_word = '0;
        err_word[ERR_LO +: ERR_W] = err_q;
        bus_err_word = bus_q;
        run_en   = valid && (cur_state == ST_RUN);
        pause_en = valid && (cur_state == ST_PAUSE);
        irq = (|(err_q & ien_q[ERR_LO +: ERR_W]))
            | (|(oper_q[IEN_SVC_W-1:0] & ien_q[IEN_SVC_LO +: IEN_SVC_W]))
            | ((|bus_q) & ien_q[IEN_BUS_BIT]);
    end

    // R12
    irq_level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !reg_wr) |=> irq);

    // R10
    swrst_quiets_irq_chk: assert property (@(posedge clk) disable iff (rst)
        swrst |=> !irq);

    // R9
    bus_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_clr && !(|bus_err_set)) |=> (bus_err_word == '0));

    // R6
    engine_modes_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({run_en, pause_en}));

endmodule

// File: tb/test_rps_ctrl.sv
module test_rps_ctrl;
    import rps_pkg::*;

    localparam int IF_CYC  = 3;
    localparam int ENG_CYC = 3;
    localparam int BW      = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_sel = 3'd0;
    logic [15:0]   reg_wdata = 16'h0;
    logic          eng_tick = 1'b1;
    logic          mst_ready_in = 1'b0;
    logic          out_not_empty = 1'b0;
    logic          in_not_empty = 1'b0;
    logic          out_full = 1'b0;
    logic          out_svc_set = 1'b0;
    logic          in_svc_set = 1'b0;
    logic          out_done_set = 1'b0;
    logic          in_done_set = 1'b0;
    logic [4:0]    err_set = 5'd0;
    logic [BW-1:0] bus_err_set = '0;
    logic [7:0]    status_word;
    logic [15:0]   oper_word;
    logic [7:0]    err_word;
    logic [BW-1:0] bus_err_word;
    logic          run_en;
    logic          pause_en;
    logic          irq;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    rps_ctrl #(.IF_CYC(IF_CYC), .ENG_CYC(ENG_CYC), .BUS_ERR_W(BW)) i_rps_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .eng_tick(eng_tick), .mst_ready_in(mst_ready_in),
        .out_not_empty(out_not_empty), .in_not_empty(in_not_empty),
        .out_full(out_full), .out_svc_set(out_svc_set), .in_svc_set(in_svc_set),
        .out_done_set(out_done_set), .in_done_set(in_done_set),
        .err_set(err_set), .bus_err_set(bus_err_set),
        .status_word(status_word), .oper_word(oper_word), .err_word(err_word),
        .bus_err_word(bus_err_word), .run_en(run_en), .pause_en(pause_en),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [15:0] d);
        reg_wr    = 1'b1;
        reg_sel   = sel;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = 16'h0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (!status_word[2] && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic go_state(input logic [1:0] s);
        int n;
        reg_write(SEL_STATE, {14'd0, s});
        count_busy(n);
    endtask

    task automatic t_reset;
        check("R1 status", status_word, 8'h04);
        check("R1 oper", oper_word, 16'h0);
        check("R1 err", err_word, 8'h0);
        check("R1 bus", bus_err_word, 4'h0);
        check("R1 outs", {irq, run_en, pause_en}, 3'b000);
    endtask

    task automatic t_transition;
        int n;
        eng_tick = 1'b1;
        reg_write(SEL_STATE, 16'h0001);
        check("R2 busy keeps old state", status_word, 8'h00);
        check("R6 no run while busy", run_en, 1'b0);
        count_busy(n);
        check("R3 busy length", n, IF_CYC + ENG_CYC);
        check("R5 run status", status_word, 8'h05);
        check("R6 run_en", {run_en, pause_en}, 2'b10);
    endtask

    task automatic t_slow_tick;
        int n;
        eng_tick = 1'b0;
        reg_write(SEL_STATE, 16'h0003);
        repeat (20) @(negedge clk);
        check("R3 stalls without tick", status_word, 8'h01);
        check("R6 frozen modes", {run_en, pause_en}, 2'b00);
        eng_tick = 1'b1;
        count_busy(n);
        check("R3 engine ticks only", n, ENG_CYC);
        check("R6 pause", {status_word, run_en, pause_en}, {8'h07, 2'b01});
    endtask

    task automatic t_ignored;
        int n;
        reg_write(SEL_STATE, 16'h0001);
        reg_write(SEL_STATE, 16'h0000);
        count_busy(n);
        check("R4 write while busy ignored", status_word, 8'h05);
        reg_write(SEL_STATE, 16'h0002);
        check("R4 encoding 2 ignored", status_word, 8'h05);
    endtask

    task automatic t_ready;
        mst_ready_in = 1'b1;
        @(negedge clk);
        check("R5 ready bit", status_word, 8'h15);
        mst_ready_in = 1'b0;
        @(negedge clk);
        check("R5 ready cleared", status_word[4], 1'b0);
    endtask

    task automatic t_oper;
        out_not_empty = 1'b1;
        out_full      = 1'b1;
        out_svc_set   = 1'b1;
        in_done_set   = 1'b1;
        @(negedge clk);
        out_svc_set   = 1'b0;
        in_done_set   = 1'b0;
        check("R7 levels and sticky", oper_word, 16'h0950);
        reg_write(SEL_OPER, 16'h0000);
        check("R7 zero write no effect", oper_word, 16'h0950);
        reg_write(SEL_OPER, 16'h0100);
        check("R7 w1c out svc", oper_word, 16'h0850);
        out_not_empty = 1'b0;
        out_full      = 1'b0;
        in_not_empty  = 1'b1;
        reg_write(SEL_OPER, 16'h0800);
        check("R7 w1c in done", oper_word, 16'h0020);
        in_not_empty = 1'b0;
        in_svc_set   = 1'b1;
        out_done_set = 1'b1;
        @(negedge clk);
        in_svc_set   = 1'b0;
        out_done_set = 1'b0;
        check("R7 in svc out done", oper_word, 16'h0600);
        reg_write(SEL_OPER, 16'h0600);
        check("R7 cleared", oper_word, 16'h0000);
    endtask

    task automatic t_err;
        err_set = 5'b00101;
        @(negedge clk);
        err_set = 5'd0;
        check("R8 set", err_word, 8'h14);
        reg_write(SEL_ERR, 16'h0004);
        check("R8 w1c", err_word, 8'h10);
        reg_write(SEL_ERR, 16'hFF83);
        check("R8 outside bits ignored", err_word, 8'h10);
        reg_write(SEL_ERR, 16'h0010);
        check("R8 cleared", err_word, 8'h00);
    endtask

    task automatic t_bus;
        bus_err_set = 4'b0010;
        @(negedge clk);
        bus_err_set = '0;
        check("R9 set", bus_err_word, 4'h2);
        go_state(2'd1);
        check("R9 run request keeps", bus_err_word, 4'h2);
        reg_write(SEL_STATE, 16'h0000);
        check("R9 reset request clears", bus_err_word, 4'h0);
        go_state(2'd0);
        check("R9 back in reset", status_word, 8'h04);
    endtask

    task automatic t_collide;
        out_svc_set = 1'b1;
        reg_write(SEL_OPER, 16'h0100);
        out_svc_set = 1'b0;
        check("R11 set beats clear", oper_word[8], 1'b1);
        err_set = 5'b00010;
        reg_write(SEL_SWRST, 16'h0001);
        err_set = 5'd0;
        check("R11 swrst beats set", err_word, 8'h00);
        check("R10 oper flushed", oper_word, 16'h0000);
    endtask

    task automatic t_swrst;
        reg_write(SEL_IEN, 16'h0008);
        reg_write(SEL_STATE, 16'h0001);
        check("R10 busy before swrst", status_word[2], 1'b0);
        reg_write(SEL_SWRST, 16'h0001);
        check("R10 reset and valid", status_word, 8'h04);
        check("R10 no run", run_en, 1'b0);
        repeat (10) @(negedge clk);
        check("R10 change dropped", status_word, 8'h04);
        err_set = 5'b00010;
        @(negedge clk);
        err_set = 5'd0;
        check("R10 enables kept", irq, 1'b1);
        reg_write(SEL_SWRST, 16'h0000);
        check("R10 bit0 zero no reset", err_word, 8'h08);
        reg_write(SEL_SWRST, 16'h0001);
        check("R10 flags cleared", {irq, err_word}, 9'h000);
    endtask

    task automatic t_irq;
        reg_write(SEL_IEN, 16'h0008);
        err_set = 5'b01000;
        @(negedge clk);
        err_set = 5'd0;
        check("R12 masked error", irq, 1'b0);
        reg_write(SEL_IEN, 16'h0028);
        check("R12 enabled error", irq, 1'b1);
        repeat (3) @(negedge clk);
        check("R12 level held", irq, 1'b1);
        reg_write(SEL_ERR, 16'h0020);
        check("R12 cleared drops irq", irq, 1'b0);
        reg_write(SEL_IEN, 16'h0100);
        in_svc_set = 1'b1;
        @(negedge clk);
        in_svc_set = 1'b0;
        check("R12 in svc not enabled", irq, 1'b0);
        out_svc_set = 1'b1;
        @(negedge clk);
        out_svc_set = 1'b0;
        check("R12 out svc", irq, 1'b1);
        reg_write(SEL_OPER, 16'h0300);
        reg_write(SEL_IEN, 16'h0001);
        bus_err_set = 4'b1000;
        @(negedge clk);
        bus_err_set = '0;
        check("R12 bus error", irq, 1'b1);
        reg_write(SEL_STATE, 16'h0000);
        check("R12 bus cleared", irq, 1'b0);
        go_state(2'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_transition();
        t_slow_tick();
        t_ignored();
        t_ready();
        t_oper();
        t_err();
        t_bus();
        t_collide();
        t_swrst();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: got %h expected %h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule